// File: doc/BRIEF.md
# DMA Command Pointer List Walker

This block sequences descriptor fetches for one DMA channel working in pointer-list mode. Software hands it a command pointer whose low field holds a byte address divided by eight. At that address sits a list of 32-bit list entries. Each entry carries its own address field, also scaled by eight, that locates an array of four-word descriptors. Bit 31 of an entry flags the final entry of the list.

The walker reads one word at a time over a valid/ready memory read port. It gathers the command, source, destination and length words of each descriptor, then presents them as one transfer request to the data mover that follows it. It waits for that mover's completion pulse before fetching the next descriptor. Bit 31 of a command word closes its array. After the closing descriptor of the array named by the final list entry completes, the block gives a single done pulse and returns to idle.

Only single-item descriptors are executed. A command word whose mode field is not zero aborts the walk with an error pulse. A command word with the force-result bit set raises a result pulse when its transfer completes.

Top module: `cmd_ptr_walker`

## Requirements
- R1: After reset the walker is idle. `cmd_ptr_ready` is high, and `rd_req_valid`, `xfer_valid`, `walk_done`, `walk_err` and `walk_user` are low. While idle it issues no read and no transfer.
- R2: The first read of a walk is at byte address `cmd_ptr[28:0] * 8`. Each following list entry is read 4 bytes after the previous one.
- R3: A descriptor array starts at byte address `entry[28:0] * 8`. Its words are read at consecutive 4-byte addresses in the order command, source, destination, length. The next descriptor starts 16 bytes after the current one.
- R4: At most one read is outstanding. After a request is accepted, `rd_req_valid` stays low until `rd_rsp_valid` returns the word.
- R5: A transfer request presents the four captured words on `xfer_cmd`, `xfer_src`, `xfer_dst` and `xfer_len`. These stay stable while `xfer_valid` is high and `xfer_ready` is low.
- R6: No memory read is issued between acceptance of a transfer and its `xfer_done` pulse.
- R7: A command word with bit 31 set ends its array. The walk then moves to the next list entry, unless the current entry had bit 31 set.
- R8: When the last descriptor of the final array completes, `walk_done` pulses for exactly one cycle, in the cycle after `xfer_done`. The walker is then idle. No done pulse occurs earlier in the walk.
- R9: A command word whose mode field `[1:0]` is not 0 (1 = scatter/gather, 2 = indirect, 3 = box) is not issued. The rest of that descriptor is not fetched. `walk_err` pulses once, and the walker returns to idle without a done pulse.
- R10: A completed descriptor whose command bit 22 is set produces a one-cycle `walk_user` pulse. Descriptors without that bit produce none.
- R11: `xfer_dst_rci` carries command bits `[10:7]` and `xfer_src_rci` carries bits `[6:3]`. Zero means no flow control.
- R12: While a walk is in progress, `cmd_ptr_ready` is low and `cmd_ptr_valid` is ignored. A pointer offered then starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_ptr_valid | input | 1 | Command pointer offered |
| cmd_ptr | input | DW | Command pointer; bits [28:0] are byte address / 8 |
| cmd_ptr_ready | output | 1 | Walker idle and accepting a pointer |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_addr | output | AW | Byte address of the word to read |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | DW | Read data word |
| xfer_valid | output | 1 | Transfer request to the data mover |
| xfer_ready | input | 1 | Data mover accepts the request |
| xfer_cmd | output | DW | Descriptor command word |
| xfer_src | output | DW | Source address word |
| xfer_dst | output | DW | Destination address word |
| xfer_len | output | DW | Length word |
| xfer_src_rci | output | 4 | Source rate-control interface select |
| xfer_dst_rci | output | 4 | Destination rate-control interface select |
| xfer_done | input | 1 | Data mover completion pulse |
| walk_done | output | 1 | One-cycle pulse at end of a full walk |
| walk_err | output | 1 | One-cycle pulse when a walk aborts on an unsupported mode |
| walk_user | output | 1 | One-cycle pulse when a force-result descriptor completes |

## Verification
The bound checker watches the handshake rules on every cycle:
- the single outstanding read;
- the silence of the read port while a transfer is in flight;
- the stability of a stalled transfer request;
- word alignment of read addresses;
- the quiet idle state;
- the single-cycle, mutually exclusive done and error pulses.

Which addresses are fetched, the order of the transfers, the two-level termination by the last-entry and last-command bits, the mode abort, the force-result pulse and the decoded rate-control fields depend on memory contents. Only the directed scenarios show these, by comparing logged reads and transfers against lists the bench builds itself.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

  localparam int DESC_WORDS = 4;
  localparam int W_CMD      = 0;
  localparam int W_SRC      = 1;
  localparam int W_DST      = 2;
  localparam int W_LEN      = 3;

  localparam int LAST_BIT   = 31;
  localparam int FR_BIT     = 22;
  localparam int MODE_LO    = 0;
  localparam int MODE_HI    = 1;
  localparam int DRCI_LO    = 7;
  localparam int DRCI_HI    = 10;
  localparam int SRCI_LO    = 3;
  localparam int SRCI_HI    = 6;

  localparam logic [1:0] MODE_SINGLE = 2'd0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PTR_REQ,
    S_PTR_WAIT,
    S_DSC_REQ,
    S_DSC_WAIT,
    S_ISSUE,
    S_XFER_WAIT
  } walk_st_t;

endpackage

// File: rtl/cpw_rst_sync.sv
module cpw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cpw_addr_gen.sv
module cpw_addr_gen #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SHIFT = 3,
  parameter int WORDS = 4,
  localparam int FW   = AW - SHIFT,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_list,
  input  logic [FW-1:0] list_field,
  input  logic          load_array,
  input  logic [FW-1:0] array_field,
  input  logic          ptr_step,
  input  logic          word_step,
  input  logic          desc_step,
  input  logic          sel_ptr,
  output logic [AW-1:0] rd_addr,
  output logic [IW-1:0] word_idx
);

  localparam int BSH       = $clog2(DW / 8);
  localparam int WORD_STEP = DW / 8;
  localparam int DESC_STEP = WORDS * WORD_STEP;

  logic [AW-1:0] list_q, list_d;
  logic [AW-1:0] desc_q, desc_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          list_en, desc_en, idx_en;

  always_comb begin
    list_en = load_list | ptr_step;
    list_d  = load_list ? {list_field, {SHIFT{1'b0}}} : list_q + AW'(WORD_STEP);
    desc_en = load_array | desc_step;
    desc_d  = load_array ? {array_field, {SHIFT{1'b0}}} : desc_q + AW'(DESC_STEP);
    idx_en  = load_array | desc_step | word_step;
    idx_d   = word_step ? idx_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      list_q <= '0;
      desc_q <= '0;
      idx_q  <= '0;
    end else begin
      if (list_en) list_q <= list_d;
      if (desc_en) desc_q <= desc_d;
      if (idx_en)  idx_q  <= idx_d;
    end
  end

  assign rd_addr  = sel_ptr ? list_q : desc_q + (AW'(idx_q) << BSH);
  assign word_idx = idx_q;

endmodule

// File: rtl/cpw_desc_buf.sv
module cpw_desc_buf #(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IW-1:0]              wr_idx,
  input  logic [DW-1:0]              wr_data,
  output logic [WORDS-1:0][DW-1:0]   words
);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words[g] <= '0;
      else if (hit) words[g] <= wr_data;
    end
  end

endmodule

// File: rtl/cmd_ptr_walker.sv
module cmd_ptr_walker
  import cpw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_ptr_valid,
  input  logic [DW-1:0] cmd_ptr,
  output logic          cmd_ptr_ready,
  output logic          rd_req_valid,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_req_ready,
  input  logic          rd_rsp_valid,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [DW-1:0] xfer_cmd,
  output logic [DW-1:0] xfer_src,
  output logic [DW-1:0] xfer_dst,
  output logic [DW-1:0] xfer_len,
  output logic [3:0]    xfer_src_rci,
  output logic [3:0]    xfer_dst_rci,
  input  logic          xfer_done,
  output logic          walk_done,
  output logic          walk_err,
  output logic          walk_user
);

  localparam int FW       = AW - SHIFT;
  localparam int IW       = $clog2(DESC_WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(DESC_WORDS - 1);

  logic rst_n_i;

  cpw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  walk_st_t st_q, st_d;
  logic     load_list, load_array, ptr_step, word_step, desc_step, cap_word;
  logic     done_d, err_d, user_d;
  logic     done_q, err_q, user_q;
  logic     last_ptr_q;
  logic [IW-1:0] word_idx;
  logic [DESC_WORDS-1:0][DW-1:0] words;
  logic [DW-1:0] cmd_w;

  cpw_addr_gen #(.AW(AW), .DW(DW), .SHIFT(SHIFT), .WORDS(DESC_WORDS)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .load_list   (load_list),
    .list_field  (cmd_ptr[FW-1:0]),
    .load_array  (load_array),
    .array_field (rd_rsp_data[FW-1:0]),
    .ptr_step    (ptr_step),
    .word_step   (word_step),
    .desc_step   (desc_step),
    .sel_ptr     (st_q == S_PTR_REQ),
    .rd_addr     (rd_req_addr),
    .word_idx    (word_idx)
  );

  cpw_desc_buf #(.DW(DW), .WORDS(DESC_WORDS)) u_desc (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (cap_word),
    .wr_idx  (word_idx),
    .wr_data (rd_rsp_data),
    .words   (words)
  );

  assign cmd_w = words[W_CMD];

  // next-state logic
  always_comb begin
    st_d       = st_q;
    load_list  = 1'b0;
    load_array = 1'b0;
    ptr_step   = 1'b0;
    word_step  = 1'b0;
    desc_step  = 1'b0;
    cap_word   = 1'b0;
    done_d     = 1'b0;
    err_d      = 1'b0;
    user_d     = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (cmd_ptr_valid) begin
          load_list = 1'b1;
          st_d      = S_PTR_REQ;
        end
      end
      S_PTR_REQ: begin
        if (rd_req_ready) st_d = S_PTR_WAIT;
      end
      S_PTR_WAIT: begin
        if (rd_rsp_valid) begin
          load_array = 1'b1;
          ptr_step   = 1'b1;
          st_d       = S_DSC_REQ;
        end
      end
      S_DSC_REQ: begin
        if (rd_req_ready) st_d = S_DSC_WAIT;
      end
      S_DSC_WAIT: begin
        if (rd_rsp_valid) begin
          if ((word_idx == '0) && (rd_rsp_data[MODE_HI:MODE_LO] != MODE_SINGLE)) begin
            err_d = 1'b1;
            st_d  = S_IDLE;
          end else begin
            cap_word = 1'b1;
            if (word_idx == LAST_IDX) begin
              st_d = S_ISSUE;
            end else begin
              word_step = 1'b1;
              st_d      = S_DSC_REQ;
            end
          end
        end
      end
      S_ISSUE: begin
        if (xfer_ready) st_d = S_XFER_WAIT;
      end
      S_XFER_WAIT: begin
        if (xfer_done) begin
          user_d = cmd_w[FR_BIT];
          if (cmd_w[LAST_BIT]) begin
            if (last_ptr_q) begin
              done_d = 1'b1;
              st_d   = S_IDLE;
            end else begin
              st_d = S_PTR_REQ;
            end
          end else begin
            desc_step = 1'b1;
            st_d      = S_DSC_REQ;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q       <= S_IDLE;
      last_ptr_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      user_q     <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      user_q <= user_d;
      if (load_array) last_ptr_q <= rd_rsp_data[LAST_BIT];
    end
  end

  assign cmd_ptr_ready = (st_q == S_IDLE);
  assign rd_req_valid  = (st_q == S_PTR_REQ) || (st_q == S_DSC_REQ);
  assign xfer_valid    = (st_q == S_ISSUE);
  assign xfer_cmd      = cmd_w;
  assign xfer_src      = words[W_SRC];
  assign xfer_dst      = words[W_DST];
  assign xfer_len      = words[W_LEN];
  assign xfer_dst_rci  = cmd_w[DRCI_HI:DRCI_LO];
  assign xfer_src_rci  = cmd_w[SRCI_HI:SRCI_LO];
  assign walk_done     = done_q;
  assign walk_err      = err_q;
  assign walk_user     = user_q;

  logic unused_bits;
  assign unused_bits = ^{cmd_ptr, rd_rsp_data};

endmodule

// File: rtl/cmd_ptr_walker_chk.sv
module cmd_ptr_walker_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ptr_ready,
  input logic          rd_req_valid,
  input logic [AW-1:0] rd_req_addr,
  input logic          rd_req_ready,
  input logic          rd_rsp_valid,
  input logic          xfer_valid,
  input logic          xfer_ready,
  input logic [DW-1:0] xfer_cmd,
  input logic [DW-1:0] xfer_src,
  input logic [DW-1:0] xfer_dst,
  input logic [DW-1:0] xfer_len,
  input logic          xfer_done,
  input logic          walk_done,
  input logic          walk_err
);

  logic rd_pend_q, xf_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      xf_pend_q <= 1'b0;
    end else begin
      if (rd_req_valid && rd_req_ready) rd_pend_q <= 1'b1;
      else if (rd_rsp_valid)            rd_pend_q <= 1'b0;
      if (xfer_valid && xfer_ready)     xf_pend_q <= 1'b1;
      else if (xfer_done)               xf_pend_q <= 1'b0;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ptr_ready |-> (!rd_req_valid && !xfer_valid));

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[1:0] == 2'b00));

  a_r4_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend_q |-> !rd_req_valid);

  a_r5_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_cmd) && $stable(xfer_src)
                                     && $stable(xfer_dst) && $stable(xfer_len)));

  a_r6_no_fetch_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    xf_pend_q |-> !rd_req_valid);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  a_r8_done_after_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> ($past(xfer_done) && cmd_ptr_ready));

  a_r9_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    walk_err |-> (!walk_done && cmd_ptr_ready));

endmodule

bind cmd_ptr_walker cmd_ptr_walker_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ptr_ready (cmd_ptr_ready),
  .rd_req_valid  (rd_req_valid),
  .rd_req_addr   (rd_req_addr),
  .rd_req_ready  (rd_req_ready),
  .rd_rsp_valid  (rd_rsp_valid),
  .xfer_valid    (xfer_valid),
  .xfer_ready    (xfer_ready),
  .xfer_cmd      (xfer_cmd),
  .xfer_src      (xfer_src),
  .xfer_dst      (xfer_dst),
  .xfer_len      (xfer_len),
  .xfer_done     (xfer_done),
  .walk_done     (walk_done),
  .walk_err      (walk_err)
);

// File: tb/cmd_ptr_walker_tb_top.sv
module cmd_ptr_walker_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cmd_ptr_valid;
  logic [DW-1:0] cmd_ptr;
  logic          cmd_ptr_ready;
  logic          rd_req_valid;
  logic [AW-1:0] rd_req_addr;
  logic          rd_req_ready;
  logic          rd_rsp_valid;
  logic [DW-1:0] rd_rsp_data;
  logic          xfer_valid, xfer_ready;
  logic [DW-1:0] xfer_cmd, xfer_src, xfer_dst, xfer_len;
  logic [3:0]    xfer_src_rci, xfer_dst_rci;
  logic          xfer_done;
  logic          walk_done, walk_err, walk_user;

  cmd_ptr_walker #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_ptr_valid(cmd_ptr_valid), .cmd_ptr(cmd_ptr), .cmd_ptr_ready(cmd_ptr_ready),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_cmd(xfer_cmd), .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_len(xfer_len),
    .xfer_src_rci(xfer_src_rci), .xfer_dst_rci(xfer_dst_rci), .xfer_done(xfer_done),
    .walk_done(walk_done), .walk_err(walk_err), .walk_user(walk_user)
  );

  logic [31:0] mem [0:255];
  int checks = 0;
  int errors = 0;

  // memory and data-mover models
  int n_rd, n_xfer, n_done, n_err, n_user, n_bad_fetch, n_bad_rd;
  logic [31:0] rd_log [0:255];
  logic [31:0] xc_log [0:31];
  logic [31:0] xs_log [0:31];
  logic [31:0] xd_log [0:31];
  logic [31:0] xl_log [0:31];
  logic [7:0]  rci_log [0:31];
  int rlat = 1;
  int xlat = 3;
  int rd_cnt, xf_cnt, tick;
  logic rd_busy, xf_busy;
  logic [31:0] rd_addr_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_rd <= 0; n_xfer <= 0; n_done <= 0; n_err <= 0; n_user <= 0;
      n_bad_fetch <= 0; n_bad_rd <= 0;
      rd_cnt <= 0; xf_cnt <= 0; tick <= 0;
      rd_busy <= 1'b0; xf_busy <= 1'b0; rd_addr_q <= '0;
      rd_req_ready <= 1'b0; rd_rsp_valid <= 1'b0; rd_rsp_data <= '0;
      xfer_ready <= 1'b0; xfer_done <= 1'b0;
    end else begin
      tick         <= tick + 1;
      rd_req_ready <= (tick % 3) != 1;
      xfer_ready   <= ~xfer_ready;
      rd_rsp_valid <= 1'b0;
      xfer_done    <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
        if (rd_busy) n_bad_rd <= n_bad_rd + 1;
        if (xf_busy) n_bad_fetch <= n_bad_fetch + 1;
        if (n_rd < 256) rd_log[n_rd] <= rd_req_addr;
        n_rd      <= n_rd + 1;
        rd_busy   <= 1'b1;
        rd_cnt    <= rlat;
        rd_addr_q <= rd_req_addr;
      end else if (rd_cnt != 0) begin
        rd_cnt <= rd_cnt - 1;
        if (rd_cnt == 1) begin
          rd_rsp_valid <= 1'b1;
          rd_rsp_data  <= mem[rd_addr_q[9:2]];
          rd_busy      <= 1'b0;
        end
      end
      if (xfer_valid && xfer_ready) begin
        if (n_xfer < 32) begin
          xc_log[n_xfer]  <= xfer_cmd;
          xs_log[n_xfer]  <= xfer_src;
          xd_log[n_xfer]  <= xfer_dst;
          xl_log[n_xfer]  <= xfer_len;
          rci_log[n_xfer] <= {xfer_dst_rci, xfer_src_rci};
        end
        n_xfer  <= n_xfer + 1;
        xf_busy <= 1'b1;
        xf_cnt  <= xlat;
      end else if (xf_cnt != 0) begin
        xf_cnt <= xf_cnt - 1;
        if (xf_cnt == 1) begin
          xfer_done <= 1'b1;
          xf_busy   <= 1'b0;
        end
      end
      if (walk_done) n_done <= n_done + 1;
      if (walk_err)  n_err  <= n_err + 1;
      if (walk_user) n_user <= n_user + 1;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkptr(input bit last, input logic [31:0] byte_addr);
    return {last, 2'b00, byte_addr[31:3]};
  endfunction

  function automatic logic [31:0] mkcmd(input bit last, input bit fr, input logic [1:0] mode,
                                        input logic [3:0] drci, input logic [3:0] srci);
    logic [31:0] c;
    c = '0;
    c[31] = last; c[22] = fr; c[10:7] = drci; c[6:3] = srci; c[1:0] = mode;
    return c;
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] l);
    mem[a[9:2]]     = c;
    mem[a[9:2] + 1] = s;
    mem[a[9:2] + 2] = d;
    mem[a[9:2] + 3] = l;
  endtask

  task automatic start_walk(input logic [31:0] byte_addr);
    @(negedge clk);
    cmd_ptr_valid = 1'b1;
    cmd_ptr       = {3'b001, byte_addr[31:3]};
    @(negedge clk);
    cmd_ptr_valid = 1'b0;
  endtask

  task automatic wait_end(input string req);
    int base = n_done + n_err;
    int t = 0;
    while ((n_done + n_err) == base && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check({req, " walk ends"}, (t < 5000), 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ready", cmd_ptr_ready, 1);
    check("R1 rd_req_valid", rd_req_valid, 0);
    check("R1 xfer_valid", xfer_valid, 0);
    check("R1 pulses", {walk_done, walk_err, walk_user}, 0);
    repeat (5) @(negedge clk);
    check("R1 no reads while idle", n_rd, 0);
  endtask

  task automatic t_single();
    int r0 = n_rd, x0 = n_xfer, d0 = n_done, e0 = n_err;
    mem[32'h100 >> 2] = mkptr(1, 32'h208);
    put_desc(32'h208, mkcmd(1, 0, 2'd0, 4'h3, 4'h5), 32'hA000_0000, 32'hB000_0010, 32'd64);
    start_walk(32'h100);
    wait_end("R8");
    check("R2 first read addr", rd_log[r0], 32'h100);
    check("R3 cmd word addr", rd_log[r0 + 1], 32'h208);
    check("R3 len word addr", rd_log[r0 + 4], 32'h214);
    check("R3 read count", n_rd - r0, 5);
    check("R5 xfer count", n_xfer - x0, 1);
    check("R5 cmd", xc_log[x0], mkcmd(1, 0, 2'd0, 4'h3, 4'h5));
    check("R5 src", xs_log[x0], 32'hA000_0000);
    check("R5 dst", xd_log[x0], 32'hB000_0010);
    check("R5 len", xl_log[x0], 32'd64);
    check("R11 dst/src rci", rci_log[x0], 8'h35);
    check("R8 one done", n_done - d0, 1);
    check("R8 no err", n_err - e0, 0);
    check("R8 idle after done", cmd_ptr_ready, 1);
  endtask

  task automatic t_multi();
    int r0 = n_rd, x0 = n_xfer, d0 = n_done;
    mem[32'h040 >> 2] = mkptr(0, 32'h300);
    mem[32'h044 >> 2] = mkptr(1, 32'h380);
    put_desc(32'h300, mkcmd(0, 0, 2'd0, 4'h0, 4'h0), 32'h1000, 32'h2000, 32'd8);
    put_desc(32'h310, mkcmd(0, 0, 2'd0, 4'h0, 4'h0), 32'h1001, 32'h2001, 32'd8);
    put_desc(32'h320, mkcmd(1, 0, 2'd0, 4'h0, 4'h0), 32'h1002, 32'h2002, 32'd8);
    put_desc(32'h380, mkcmd(1, 0, 2'd0, 4'hA, 4'h0), 32'h1003, 32'h2003, 32'd4);
    start_walk(32'h040);
    wait_end("R7");
    check("R7 xfer count", n_xfer - x0, 4);
    for (int i = 0; i < 4; i++) check("R7 order", xs_log[x0 + i], 32'h1000 + i);
    check("R3 second desc addr", rd_log[r0 + 5], 32'h310);
    check("R2 next entry addr", rd_log[r0 + 13], 32'h044);
    check("R3 second array addr", rd_log[r0 + 14], 32'h380);
    check("R3 read count", n_rd - r0, 18);
    check("R8 single done", n_done - d0, 1);
    check("R11 dst rci only", rci_log[x0 + 3], 8'hA0);
  endtask

  task automatic t_user();
    int u0 = n_user, d0 = n_done;
    mem[32'h0C0 >> 2] = mkptr(1, 32'h3C0);
    put_desc(32'h3C0, mkcmd(0, 1, 2'd0, 4'h0, 4'h0), 32'h5000, 32'h6000, 32'd1);
    put_desc(32'h3D0, mkcmd(1, 0, 2'd0, 4'h0, 4'h0), 32'h5001, 32'h6001, 32'd1);
    start_walk(32'h0C0);
    wait_end("R10");
    check("R10 one forced result", n_user - u0, 1);
    check("R10 done", n_done - d0, 1);
  endtask

  task automatic t_mode();
    int r0 = n_rd, x0 = n_xfer, d0 = n_done, e0 = n_err;
    mem[32'h0D0 >> 2] = mkptr(1, 32'h280);
    put_desc(32'h280, mkcmd(1, 0, 2'd2, 4'h0, 4'h0), 32'h7000, 32'h7100, 32'd4);
    start_walk(32'h0D0);
    wait_end("R9");
    check("R9 no xfer", n_xfer - x0, 0);
    check("R9 err pulse", n_err - e0, 1);
    check("R9 no done", n_done - d0, 0);
    check("R9 stop after cmd", n_rd - r0, 2);
    check("R9 idle", cmd_ptr_ready, 1);
    // valid descriptor then scatter/gather mode in the second one
    x0 = n_xfer; e0 = n_err; d0 = n_done;
    mem[32'h0D8 >> 2] = mkptr(1, 32'h2C0);
    put_desc(32'h2C0, mkcmd(0, 0, 2'd0, 4'h0, 4'h0), 32'h7200, 32'h7300, 32'd4);
    put_desc(32'h2D0, mkcmd(1, 0, 2'd1, 4'h0, 4'h0), 32'h7201, 32'h7301, 32'd4);
    start_walk(32'h0D8);
    wait_end("R9");
    check("R9 only first issued", n_xfer - x0, 1);
    check("R9 err on second", n_err - e0, 1);
    check("R9 no done 2", n_done - d0, 0);
  endtask

  task automatic t_busy();
    int x0 = n_xfer, e0 = n_err, d0 = n_done;
    logic saw_ready;
    rlat = 3;
    xlat = 20;
    start_walk(32'h100);
    cmd_ptr_valid = 1'b1;
    cmd_ptr       = {3'b001, 29'(32'h0D0 >> 3)};
    saw_ready = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cmd_ptr_ready) saw_ready = 1'b1;
    end
    cmd_ptr_valid = 1'b0;
    check("R12 ready low while busy", saw_ready, 0);
    wait_end("R12");
    check("R12 only first walk", n_xfer - x0, 1);
    check("R12 no err from ignored ptr", n_err - e0, 0);
    check("R12 done", n_done - d0, 1);
    check("R4 one read outstanding", n_bad_rd, 0);
    check("R6 no fetch during xfer", n_bad_fetch, 0);
    rlat = 1;
    xlat = 3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n         = 1'b0;
    cmd_ptr_valid = 1'b0;
    cmd_ptr       = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_user();
    t_mode();
    t_busy();
    summary();
    $finish;
  end

endmodule